// File: doc/BRIEF.md
# Two-Channel Receive Queue Burst Reader

This block is the read side of a two-channel serial receive path. Each channel keeps a 64-entry queue, and every entry holds a received data byte together with the line-status byte captured with it. A receiver writes into each queue through its own push port. A host then drains a queue through one of three address windows. Every window reads the same queue, so the host picks whichever suits the access.

The first window returns one data byte per read. The second returns up to four data bytes per 32-bit word, which is the fast way to empty a queue. The third returns up to two entries per word, with each status byte placed in the byte lane just below its data byte. The block decodes the word address and byte enables, removes exactly the entries that the read hands back, and registers the assembled word. The word appears one cycle after the read strobe. Any byte lane the queue cannot fill reads as zero.

Top module: `rxq_burst_reader`

## Requirements
- R1: The single-byte window is word address offset 0x00 inside a channel's 128-word region (byte 0x000 for channel 0, 0x200 for channel 1). A read there with byte enable bit 0 set returns the oldest data byte in bits 7:0, returns zero in bits 31:8, and removes one entry.
- R2: The packed window is word offsets 0x40 to 0x5F (bytes 0x100 to 0x17F, and 0x300 to 0x37F for channel 1). A read there with all four byte enables set returns the four oldest data bytes, the oldest in bits 7:0 and the newest in bits 31:24, and removes four entries.
- R3: The paired window is word offsets 0x60 to 0x7F (bytes 0x180 to 0x1FF, and 0x380 to 0x3FF for channel 1). A read there with all four byte enables set returns two entries, laid out as status n in bits 7:0, data n in bits 15:8, status n+1 in bits 23:16 and data n+1 in bits 31:24, and removes two entries.
- R4: A read with byte enables 4'b0011 is a 16-bit read. In the paired window it returns one status/data pair in bits 15:0 and removes one entry. In the packed window it returns two data bytes and removes two entries. In the packed window, byte enables 4'b0001 return one data byte and remove one entry.
- R5: The following reads return zero and remove nothing: any other byte enable pattern in the packed or paired windows, a single-byte window read with byte enable bit 0 clear, and any other offset in a channel region.
- R6: When fewer entries remain than a read asks for, the block delivers the remaining entries in their normal lanes, returns zero in the lanes it cannot fill, and removes only the entries it delivered. A read of an empty queue returns zero and removes nothing.
- R7: Read data is registered. It appears in the cycle after the cycle in which the read strobe is high, and it is zero in any cycle that does not follow a read.
- R8: Each channel's level output counts pushes minus removed entries and stays within 0 to 64. A full queue empties in 16 consecutive packed 32-bit reads or in 32 consecutive paired 32-bit reads.
- R9: A push into a full queue is dropped and leaves the queue contents unchanged. It sets that channel's overrun flag, which then stays set until reset.
- R10: The channel field of the word address is bit 7. A read affects only the queue of the channel it addresses.
- R11: After reset, both levels are zero, both overrun flags are clear and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 2 | Push strobe, one bit per channel |
| push_data | input | 16 | Received data byte per channel, channel c in bits 8c+7:8c |
| push_stat | input | 16 | Line-status byte per channel, same lane layout |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Word address (byte address bits 9:2) |
| rd_be | input | 4 | Byte enables of the read |
| rd_data | output | 32 | Read word, valid one cycle after rd_en |
| level | output | 14 | Queue level per channel, channel c in bits 7c+6:7c |
| overrun | output | 2 | Sticky overrun flag per channel |

## Verification
Queues are loaded with distinct, incrementing data and status values, so a swapped lane, a status byte standing in for its data byte, or an entry removed twice each shows up as a wrong byte. Each window is read at full and at partial width, and the results tell apart how many entries each width removes. Reads that ask for more entries than remain, and reads of an empty queue, show that short words are padded with zeros and that nothing extra is removed. Back-to-back full drains through the packed and paired windows check the level bookkeeping at the boundaries. Interleaving pushes and reads on both channels shows that the channels do not interfere.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_HOLD = 2'd1,
        WIN_PACK = 2'd2,
        WIN_PAIR = 2'd3
    } win_e;

    typedef struct packed {
        logic [7:0] stat;
        logic [7:0] data;
    } entry_t;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  entry_t           push_entry,
    input  logic [2:0]       pop_n,
    output entry_t           peek [LANES],
    output logic [LVL_W-1:0] level,
    output logic             overrun
);
    // DEPTH must be a power of two: pointers wrap naturally.
    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [LVL_W-1:0] level;
        logic             overrun;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    entry_t   mem [DEPTH];
    logic     push_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push_valid && (st_q.level != LVL_W'(DEPTH));
        if (push_valid && !push_ok) begin
            st_d.overrun = 1'b1;
        end
        if (push_ok) begin
            st_d.wr_ptr = st_q.wr_ptr + PTR_W'(1);
        end
        st_d.rd_ptr = st_q.rd_ptr + PTR_W'(pop_n);
        st_d.level  = st_q.level + LVL_W'(push_ok) - LVL_W'(pop_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[st_q.wr_ptr] <= push_entry;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_peek
        assign peek[i] = mem[st_q.rd_ptr + PTR_W'(i)];
    end

    assign level   = st_q.level;
    assign overrun = st_q.overrun;

    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level <= LVL_W'(DEPTH));
    p_pop_within_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        LVL_W'(pop_n) <= st_q.level);
    p_full_push_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && st_q.level == LVL_W'(DEPTH)) |=> st_q.overrun);
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.overrun |=> st_q.overrun);
endmodule

// File: rtl/rxq_decode.sv
module rxq_decode
    import rxq_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = 7 + CH_W
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [3:0]        rd_be,
    output logic [CH_W-1:0]   ch,
    output win_e              win,
    output logic [2:0]        req
);
    logic [6:0] off;

    always_comb begin
        off = rd_addr[6:0];
        ch  = rd_addr[ADDR_W-1 -: CH_W];
        win = WIN_NONE;
        req = 3'd0;
        if (32'(ch) < NUM_CH) begin
            if (off == 7'h00) begin
                win = WIN_HOLD;
                req = rd_be[0] ? 3'd1 : 3'd0;
            end else if (off[6:5] == 2'b10) begin
                win = WIN_PACK;
                case (rd_be)
                    4'b1111: req = 3'd4;
                    4'b0011: req = 3'd2;
                    4'b0001: req = 3'd1;
                    default: req = 3'd0;
                endcase
            end else if (off[6:5] == 2'b11) begin
                win = WIN_PAIR;
                case (rd_be)
                    4'b1111: req = 3'd2;
                    4'b0011: req = 3'd1;
                    default: req = 3'd0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxq_pack.sv
module rxq_pack
    import rxq_pkg::*;
(
    input  win_e        win,
    input  logic [2:0]  cnt,
    input  entry_t      peek [LANES],
    output logic [31:0] word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < LANES; i++) begin
            unique case (win)
                WIN_HOLD: if (i == 0 && cnt != 3'd0) word[7:0] = peek[0].data;
                WIN_PACK: if (3'(i) < cnt) word[8*i +: 8] = peek[i].data;
                WIN_PAIR: if (i < 2 && 3'(i) < cnt)
                              word[16*i +: 16] = {peek[i].data, peek[i].stat};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxq_burst_reader.sv
module rxq_burst_reader
    import rxq_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DEPTH  = 64,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = 7 + CH_W,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       push_valid,
    input  logic [NUM_CH*8-1:0]     push_data,
    input  logic [NUM_CH*8-1:0]     push_stat,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [3:0]              rd_be,
    output logic [31:0]             rd_data,
    output logic [NUM_CH*LVL_W-1:0] level,
    output logic [NUM_CH-1:0]       overrun
);
    typedef struct packed {
        logic [31:0] rd_data;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [CH_W-1:0]  sel_ch;
    win_e             win;
    logic [2:0]       req;
    logic [2:0]       take;
    logic [LVL_W-1:0] sel_level;
    logic [31:0]      word;
    logic [LVL_W-1:0] lvl_ch  [NUM_CH];
    logic [2:0]       pop_ch  [NUM_CH];
    entry_t           peek_ch [NUM_CH][LANES];
    entry_t           sel_peek [LANES];

    rxq_decode #(.NUM_CH(NUM_CH)) u_decode (
        .rd_addr (rd_addr),
        .rd_be   (rd_be),
        .ch      (sel_ch),
        .win     (win),
        .req     (req)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        entry_t ent;
        assign ent.data = push_data[8*c +: 8];
        assign ent.stat = push_stat[8*c +: 8];
        assign pop_ch[c] = (rd_en && 32'(sel_ch) == c) ? take : 3'd0;

        rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (push_valid[c]),
            .push_entry (ent),
            .pop_n      (pop_ch[c]),
            .peek       (peek_ch[c]),
            .level      (lvl_ch[c]),
            .overrun    (overrun[c])
        );
        assign level[c*LVL_W +: LVL_W] = lvl_ch[c];
    end

    always_comb begin
        sel_level = lvl_ch[0];
        for (int l = 0; l < LANES; l++) sel_peek[l] = peek_ch[0][l];
        for (int c = 1; c < NUM_CH; c++) begin
            if (32'(sel_ch) == c) begin
                sel_level = lvl_ch[c];
                for (int l = 0; l < LANES; l++) sel_peek[l] = peek_ch[c][l];
            end
        end
        take = (LVL_W'(req) < sel_level) ? req : 3'(sel_level);
    end

    rxq_pack u_pack (
        .win  (win),
        .cnt  (take),
        .peek (sel_peek),
        .word (word)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rd_data = rd_en ? word : 32'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd_data;

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == 32'd0);
    p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_level == '0) |=> rd_data == 32'd0);
    p_hold_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && win == WIN_HOLD) |=> rd_data[31:8] == 24'd0);
    p_no_pop_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && win == WIN_NONE) |=> rd_data == 32'd0);
endmodule

// File: tb/rxq_burst_reader_bench.sv
module rxq_burst_reader_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  push_valid = '0;
    logic [15:0] push_data = '0;
    logic [15:0] push_stat = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [3:0]  rd_be = '0;
    logic [31:0] rd_data;
    logic [13:0] level;
    logic [1:0]  overrun;

    int checks = 0;
    int failures = 0;
    logic pend = 1'b0;

    logic [15:0] model0 [$];
    logic [15:0] model1 [$];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_burst_reader u_rxq_burst_reader (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_stat(push_stat), .rd_en(rd_en), .rd_addr(rd_addr), .rd_be(rd_be),
        .rd_data(rd_data), .level(level), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each read result one cycle after the strobe
    always @(posedge clk) pend <= rd_en;
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data === e, t, rd_data, e);
        end
    end

    function automatic int model_size(input int ch);
        return (ch == 0) ? model0.size() : model1.size();
    endfunction

    function automatic logic [15:0] model_pop(input int ch);
        return (ch == 0) ? model0.pop_front() : model1.pop_front();
    endfunction

    task automatic push(input int ch, input logic [7:0] d, input logic [7:0] s);
        push_valid[ch] = 1'b1;
        push_data[8*ch +: 8] = d;
        push_stat[8*ch +: 8] = s;
        if (model_size(ch) < 64) begin
            if (ch == 0) model0.push_back({s, d});
            else model1.push_back({s, d});
        end
        @(negedge clk);
        push_valid[ch] = 1'b0;
    endtask

    // driver: computes the expected word from the requirements and queues it
    task automatic rd(input int ch, input logic [6:0] off, input logic [3:0] be,
                      input string tag);
        int req;
        int k;
        logic [31:0] w;
        logic [15:0] e;
        req = 0;
        w = '0;
        if (off == 7'h00) req = be[0] ? 1 : 0;
        else if (off[6:5] == 2'b10)
            req = (be == 4'hF) ? 4 : (be == 4'h3) ? 2 : (be == 4'h1) ? 1 : 0;
        else if (off[6:5] == 2'b11)
            req = (be == 4'hF) ? 2 : (be == 4'h3) ? 1 : 0;
        k = (req < model_size(ch)) ? req : model_size(ch);
        for (int i = 0; i < k; i++) begin
            e = model_pop(ch);
            if (off[6:5] == 2'b11) w[16*i +: 16] = {e[7:0], e[15:8]};
            else w[8*i +: 8] = e[7:0];
        end
        exp_q.push_back(w);
        tag_q.push_back(tag);
        rd_en = 1'b1;
        rd_addr = {ch[0], off};
        rd_be = be;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_level(input int ch, input int exp, input string tag);
        chk(level[7*ch +: 7] == 7'(exp), tag, 32'(level[7*ch +: 7]), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk_level(0, 0, "R11 level ch0");
        chk_level(1, 0, "R11 level ch1");
        chk(overrun == 2'b00, "R11 overrun", 32'(overrun), 32'd0);
        chk(rd_data == 32'd0, "R11 rd_data", rd_data, 32'd0);

        for (int i = 0; i < 12; i++) push(0, 8'h10 + 8'(i), 8'h80 + 8'(i));
        chk_level(0, 12, "R8 level after 12 pushes");
        rd(0, 7'h00, 4'h1, "R1 single-byte read");
        rd(0, 7'h40, 4'hF, "R2 packed 32-bit read");
        rd(0, 7'h60, 4'hF, "R3 paired 32-bit read");
        rd(0, 7'h7F, 4'h3, "R4 paired 16-bit read");
        rd(0, 7'h41, 4'h3, "R4 packed 16-bit read");
        rd(0, 7'h42, 4'h1, "R4 packed 8-bit read");
        rd(0, 7'h40, 4'h4, "R5 odd byte enables");
        rd(0, 7'h10, 4'hF, "R5 unmapped offset");
        rd(0, 7'h00, 4'h2, "R5 single-byte without lane 0");
        @(negedge clk);
        chk_level(0, 1, "R5 nothing removed by ignored reads");
        chk(rd_data == 32'd0, "R7 idle cycle reads zero", rd_data, 32'd0);
        push(0, 8'h55, 8'h01);
        rd(0, 7'h44, 4'hF, "R6 short packed read");
        rd(0, 7'h64, 4'hF, "R6 empty paired read");
        @(negedge clk);
        chk_level(0, 0, "R6 level after short read");

        // R10 channel independence
        push(1, 8'hA1, 8'h11);
        push(0, 8'hB1, 8'h22);
        push(1, 8'hA2, 8'h12);
        push(0, 8'hB2, 8'h23);
        push(1, 8'hA3, 8'h13);
        rd(1, 7'h40, 4'hF, "R10 packed read of channel 1");
        @(negedge clk);
        chk_level(0, 2, "R10 channel 0 untouched");
        chk_level(1, 0, "R10 channel 1 drained");
        rd(0, 7'h00, 4'h1, "R10 channel 0 first byte");
        rd(0, 7'h00, 4'h1, "R10 channel 0 second byte");

        // R8/R9 full fill, overrun, 16 packed drains
        for (int i = 0; i < 64; i++) push(1, 8'(i * 3), 8'(i));
        chk_level(1, 64, "R8 full level");
        push(1, 8'hEE, 8'hEE);
        @(negedge clk);
        chk(overrun == 2'b10, "R9 overrun on channel 1 only", 32'(overrun), 32'd2);
        chk_level(1, 64, "R9 dropped push keeps level");
        for (int i = 0; i < 16; i++) rd(1, 7'(7'h40 + i), 4'hF, "R8 packed drain");
        @(negedge clk);
        chk_level(1, 0, "R8 empty after 16 packed reads");
        chk(overrun == 2'b10, "R9 overrun sticky", 32'(overrun), 32'd2);

        // R8 32 paired drains
        for (int i = 0; i < 64; i++) push(0, 8'hC0 ^ 8'(i), 8'(i * 5));
        for (int i = 0; i < 32; i++) rd(0, 7'(7'h60 + i), 4'hF, "R8 paired drain");
        @(negedge clk);
        chk_level(0, 0, "R8 empty after 32 paired reads");
        rd(0, 7'h60, 4'hF, "R6 empty after drain");
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard all results seen", 32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule